// File: doc/BRIEF.md
# Memory-Mapped GPIO Port

This block is a general-purpose I/O port that a processor reaches over a simple two-phase peripheral bus. A select strobe opens a transfer and an enable strobe completes it. The number of pins equals the register width, which is 8, 16, 32 or 64 bits. Each pin has an output latch and a direction bit. The pad is tri-state: the block supplies a drive value and an output-enable per pin, and the pad cell outside the block does the driving.

Software changes the latch in one of three ways:

- It writes the whole latch at once through the data register.
- It raises chosen bits by writing a mask to the set register.
- It lowers chosen bits by writing a mask to the clear register.

Reading the data register returns the pin levels after a two-flop synchronizer. Three elaboration parameters fix how the port is seen from the bus:

- whether a direction bit of 1 means output or means input;
- whether pin numbering is mirrored across the register;
- whether the byte lanes of every access are reversed.

Top module: `mmio_gpio_port`

## Requirements
- R1: After reset every latch bit is 0 and every pin is an input (`pin_oe` all 0). A read of the set register (offset 0x4) returns 0. A read of the direction register (offset 0xC) returns all zeros when DIR_IS_INPUT=0 and all ones when DIR_IS_INPUT=1.
- R2: A write access to offset 0x0 loads the latch with the written word. `pin_out` shows the new value from the clock edge that completes the access.
- R3: A write access to offset 0x4 sets every latch bit whose mask bit is 1 and leaves all other latch bits unchanged.
- R4: A write access to offset 0x8 clears every latch bit whose mask bit is 1 and leaves all other latch bits unchanged.
- R5: A write access to offset 0xC loads the direction register. With DIR_IS_INPUT=0, a 1 drives the pin (`pin_oe`=1). With DIR_IS_INPUT=1, a 1 makes the pin an input (`pin_oe`=0).
- R6: A read of offset 0x0 returns the levels on `pin_in`, once they have been stable for at least two clock edges.
- R7: With BIT_REVERSE=1, logical pin n corresponds to register bit WIDTH-1-n. With BIT_REVERSE=0, pin n corresponds to bit n.
- R8: With BYTE_SWAP=1, the byte lanes of bus read and write data are reversed relative to the register, for 16-bit and 32-bit widths. Asking for the swap at 64 bits is an elaboration error.
- R9: Read data appears on `bus_rdata` from the clock edge that completes the read access and holds until the next read. Offset 0x4 returns the latch and offset 0xC returns the direction register. Offset 0x8 and every other offset return 0.
- R10: Only a completed write (select, enable and write all high) to offset 0x0, 0x4, 0x8 or 0xC changes state. Writes to other offsets, reads, and setup cycles without enable leave `pin_out` and `pin_oe` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Transfer select |
| bus_en | input | 1 | Access-phase enable, completes the transfer |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Byte offset of the register |
| bus_wdata | input | WIDTH | Write data |
| bus_rdata | output | WIDTH | Registered read data |
| pin_in | input | WIDTH | Pad input levels, asynchronous |
| pin_out | output | WIDTH | Pad drive values from the output latch |
| pin_oe | output | WIDTH | Pad output enables, 1 = drive |

## Verification
The hardest case is a single bus word that passes through both the byte-lane swap and the bit mirror. Both mappings are their own inverse, so a read-after-write test hides an error in either one. The bench therefore runs two instances side by side on the same bus: one plain, and one with mirroring, lane swap and inverted direction polarity. It checks the pad-side values rather than only the values read back, and includes a directed write of 0x00000001 that must appear on pin 7 of the mapped instance. Random traffic over mapped and unmapped offsets then mixes set, clear and direction writes on both instances.

// File: rtl/mmio_gpio_port.sv
module mmio_gpio_port #(
  parameter int WIDTH        = 32,
  parameter int BIT_REVERSE  = 0,
  parameter int BYTE_SWAP    = 0,
  parameter int DIR_IS_INPUT = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_sel,
  input  logic             bus_en,
  input  logic             bus_wr,
  input  logic [3:0]       bus_addr,
  input  logic [WIDTH-1:0] bus_wdata,
  output logic [WIDTH-1:0] bus_rdata,
  input  logic [WIDTH-1:0] pin_in,
  output logic [WIDTH-1:0] pin_out,
  output logic [WIDTH-1:0] pin_oe
);

  localparam int NBYTES = WIDTH / 8;
  localparam logic [3:0] OFS_DATA = 4'h0;
  localparam logic [3:0] OFS_SET  = 4'h4;
  localparam logic [3:0] OFS_CLR  = 4'h8;
  localparam logic [3:0] OFS_DIR  = 4'hC;
  localparam logic [WIDTH-1:0] DIR_RST = (DIR_IS_INPUT != 0) ? {WIDTH{1'b1}} : {WIDTH{1'b0}};

  if (WIDTH != 8 && WIDTH != 16 && WIDTH != 32 && WIDTH != 64) begin : g_bad_width
    $error("mmio_gpio_port: WIDTH must be 8, 16, 32 or 64");
  end
  if (BYTE_SWAP != 0 && WIDTH == 64) begin : g_bad_swap
    $error("mmio_gpio_port: byte-lane swap is not allowed at 64 bits");
  end

  function automatic logic [WIDTH-1:0] lane_swap(input logic [WIDTH-1:0] v);
    logic [WIDTH-1:0] r;
    r = v;
    if (BYTE_SWAP != 0)
      for (int i = 0; i < NBYTES; i++) r[8*i +: 8] = v[8*(NBYTES-1-i) +: 8];
    return r;
  endfunction

  function automatic logic [WIDTH-1:0] bit_order(input logic [WIDTH-1:0] v);
    logic [WIDTH-1:0] r;
    r = v;
    if (BIT_REVERSE != 0)
      for (int i = 0; i < WIDTH; i++) r[i] = v[WIDTH-1-i];
    return r;
  endfunction

  logic [WIDTH-1:0] latch_q, dir_q, sync1_q, sync2_q, wpins;
  logic wr_acc, rd_acc;

  assign wr_acc  = bus_sel & bus_en & bus_wr;
  assign rd_acc  = bus_sel & bus_en & ~bus_wr;
  assign wpins   = bit_order(lane_swap(bus_wdata));
  assign pin_out = latch_q;
  assign pin_oe  = (DIR_IS_INPUT != 0) ? ~dir_q : dir_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      latch_q <= '0;
      dir_q   <= DIR_RST;
    end else if (wr_acc) begin
      case (bus_addr)
        OFS_DATA: latch_q <= wpins;
        OFS_SET:  latch_q <= latch_q | wpins;
        OFS_CLR:  latch_q <= latch_q & ~wpins;
        OFS_DIR:  dir_q   <= wpins;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync1_q <= '0;
      sync2_q <= '0;
    end else begin
      sync1_q <= pin_in;
      sync2_q <= sync1_q;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) bus_rdata <= '0;
    else if (rd_acc) begin
      case (bus_addr)
        OFS_DATA: bus_rdata <= lane_swap(bit_order(sync2_q));
        OFS_SET:  bus_rdata <= lane_swap(bit_order(latch_q));
        OFS_DIR:  bus_rdata <= lane_swap(bit_order(dir_q));
        default:  bus_rdata <= '0;
      endcase
    end
  end

  a_r3_set_never_lowers: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_acc && bus_addr == OFS_SET) |=> ((pin_out & $past(pin_out)) == $past(pin_out)));

  a_r4_clear_never_raises: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_acc && bus_addr == OFS_CLR) |=> ((pin_out & ~$past(pin_out)) == '0));

  a_r10_idle_holds_pins: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_acc |=> ($stable(pin_out) && $stable(pin_oe)));

  a_r5_oe_only_on_dir_write: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_acc && bus_addr == OFS_DIR) |=> $stable(pin_oe));

  a_r9_unmapped_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_acc && bus_addr != OFS_DATA && bus_addr != OFS_SET && bus_addr != OFS_DIR) |=> (bus_rdata == '0));

  a_r9_rdata_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_acc |=> $stable(bus_rdata));

endmodule

// File: tb/test_mmio_gpio_port.sv
module test_mmio_gpio_port;
  localparam int W = 32;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sel = 1'b0, en = 1'b0, wr = 1'b0;
  logic [3:0] addr = '0;
  logic [W-1:0] wdata = '0;
  logic [W-1:0] rd_a, rd_b, pin_in_a = '0, pin_in_b = '0, out_a, out_b, oe_a, oe_b;
  logic [W-1:0] m_lat_a = '0, m_dir_a = '0, m_lat_b = '0, m_dir_b = '1;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  mmio_gpio_port #(.WIDTH(W)) i_mmio_gpio_port (
    .clk(clk), .rst_n(rst_n), .bus_sel(sel), .bus_en(en), .bus_wr(wr), .bus_addr(addr),
    .bus_wdata(wdata), .bus_rdata(rd_a), .pin_in(pin_in_a), .pin_out(out_a), .pin_oe(oe_a));

  mmio_gpio_port #(.WIDTH(W), .BIT_REVERSE(1), .BYTE_SWAP(1), .DIR_IS_INPUT(1)) i_mmio_gpio_port_alt (
    .clk(clk), .rst_n(rst_n), .bus_sel(sel), .bus_en(en), .bus_wr(wr), .bus_addr(addr),
    .bus_wdata(wdata), .bus_rdata(rd_b), .pin_in(pin_in_b), .pin_out(out_b), .pin_oe(oe_b));

  function automatic logic [W-1:0] bsw(input logic [W-1:0] v);
    return {v[7:0], v[15:8], v[23:16], v[31:24]};
  endfunction
  function automatic logic [W-1:0] rv(input logic [W-1:0] v);
    logic [W-1:0] r;
    for (int i = 0; i < W; i++) r[i] = v[W-1-i];
    return r;
  endfunction
  function automatic logic [W-1:0] exp_read(input logic [3:0] a, input logic [W-1:0] pins,
                                            input logic [W-1:0] lat, input logic [W-1:0] dir, input bit alt);
    logic [W-1:0] v;
    case (a)
      4'h0: v = pins;
      4'h4: v = lat;
      4'hC: v = dir;
      default: return '0;
    endcase
    return alt ? bsw(rv(v)) : v;
  endfunction

  task automatic check(input string req, input logic [W-1:0] got, input logic [W-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", req, got, exp);
    end
  endtask

  task automatic check_pins(input string req);
    check(req, out_a, m_lat_a);
    check(req, oe_a, m_dir_a);
    check(req, out_b, m_lat_b);
    check(req, oe_b, ~m_dir_b);
  endtask

  task automatic bus_write(input logic [3:0] a, input logic [W-1:0] d);
    logic [W-1:0] pa, pb;
    pa = d;
    pb = rv(bsw(d));
    @(negedge clk); sel = 1; wr = 1; addr = a; wdata = d; en = 0;
    @(negedge clk); en = 1;
    @(posedge clk);
    case (a)
      4'h0: begin m_lat_a = pa; m_lat_b = pb; end
      4'h4: begin m_lat_a |= pa; m_lat_b |= pb; end
      4'h8: begin m_lat_a &= ~pa; m_lat_b &= ~pb; end
      4'hC: begin m_dir_a = pa; m_dir_b = pb; end
      default: ;
    endcase
    @(negedge clk); sel = 0; en = 0; wr = 0;
  endtask

  task automatic bus_read(input string req, input logic [3:0] a);
    @(negedge clk); sel = 1; wr = 0; addr = a; en = 0;
    @(negedge clk); en = 1;
    @(posedge clk);
    @(negedge clk); sel = 0; en = 0;
    check(req, rd_a, exp_read(a, pin_in_a, m_lat_a, m_dir_a, 1'b0));
    check(req, rd_b, exp_read(a, pin_in_b, m_lat_b, m_dir_b, 1'b1));
  endtask

  initial begin
    #(20ns * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = 1234;
    void'($urandom(seed));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check_pins("R1 reset pins");
    bus_read("R1 reset set reg", 4'h4);
    bus_read("R1 reset dir reg", 4'hC);
    check("R1 alt dir reads ones", rd_b, '1);

    bus_write(4'h0, 32'h1234_5678);
    check_pins("R2 data write");
    bus_write(4'h0, 32'h0000_0001);
    check("R7 R8 alt pin 7 from bit 0", out_b, 32'h0000_0080);
    check("R2 plain pin 0", out_a, 32'h0000_0001);
    bus_write(4'h4, 32'hF0F0_0000);
    check_pins("R3 set mask");
    bus_write(4'h8, 32'h3000_0001);
    check_pins("R4 clear mask");
    bus_write(4'hC, 32'h0000_FFFF);
    check("R5 plain oe", oe_a, 32'h0000_FFFF);
    check("R5 alt oe inverted", oe_b, 32'hFFFF_0000);
    bus_read("R9 set readback", 4'h4);
    bus_read("R9 dir readback", 4'hC);
    bus_read("R9 clear reads zero", 4'h8);
    bus_read("R9 unmapped reads zero", 4'h6);

    bus_write(4'h6, 32'hFFFF_FFFF);
    check_pins("R10 unmapped write ignored");
    @(negedge clk); sel = 1; wr = 1; addr = 4'h0; wdata = '1; en = 0;
    @(negedge clk); sel = 0; wr = 0;
    check_pins("R10 setup without enable ignored");

    pin_in_a = 32'hA5C3_0F81; pin_in_b = 32'hA5C3_0F81;
    repeat (3) @(negedge clk);
    bus_read("R6 R7 R8 pin levels", 4'h0);

    for (int n = 0; n < 400; n++) begin
      logic [3:0] a;
      case ($urandom_range(5))
        0: a = 4'h0;
        1: a = 4'h4;
        2: a = 4'h8;
        3: a = 4'hC;
        default: a = 4'($urandom);
      endcase
      if ($urandom_range(1) == 1) begin
        bus_write(a, $urandom);
        check_pins("R2 R3 R4 R5 R10 random write");
      end else begin
        pin_in_a = $urandom; pin_in_b = $urandom;
        repeat (3) @(negedge clk);
        bus_read("R6 R9 random read", a);
      end
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule